// File: doc/BRIEF.md
# Programmable Blanking and Composite Sync Selector

This block sits between the beam counters of a video timing generator and the pixel output stage of a display path. It watches a horizontal and a vertical beam position and keeps four window flags: a programmable horizontal blanking range, a programmable horizontal sync range, a fixed vertical sync range and a fixed hardwired horizontal blanking range. From these flags it drives separate active-low horizontal and vertical sync outputs. It also drives one shared composite line whose meaning depends on the mode inputs.

With `blank_en` clear, the composite line carries ordinary composite sync. With `blank_en` set, the line carries only a blanking state. That state comes from either the blanking range or the sync range, and the polarity input can invert it. A receiving-side gate then blanks the pixel stream. With external blanking enabled, it blanks whenever the composite line is low. Otherwise it uses the hardwired window and ignores the line.

The normal programmed-blanking setup is `ext_blank_en=1`, `blank_en=1`, `var_sync_en=0` and `sync_pol_true=0`. This setup gives an active-low blank over the programmed start-to-stop range. The other mode combinations are legal and give inverted or substituted windows.

Top module: `blank_sync_sel`

## Requirements
- R1: A synchronous reset clears all four window flags. After reset, `hsync_n` and `vsync_n` are 1. With the normal setup, `csync_line` is 1 and `pix_blank` is 0.
- R2: On every clock edge, a window flag is set when its position input equals its start value, and is cleared when the position equals its stop value. The new flag value shows on the outputs from that edge on. With the normal setup, `csync_line` is low and `pix_blank` is high exactly while the blanking flag is set.
- R3: The window comparison is wrap-aware. If start is greater than stop, the window covers start through the end of the line and then 0 up to stop.
- R4: With `blank_en=1` and `var_sync_en=1`, the horizontal sync flag replaces the blanking flag as the blanking state on `csync_line`.
- R5: `sync_pol_true=1` inverts `csync_line` in every mode, so the blanked and visible regions swap for the receiver.
- R6: With `blank_en=0`, the asserted level of `csync_line` is the OR of the horizontal and vertical sync flags. The receiver then blanks on that composite sync.
- R7: With `ext_blank_en=0`, `pix_blank` follows only the hardwired window (`HW_BLANK_START`..`HW_BLANK_STOP`) and is independent of `csync_line`.
- R8: `hsync_n` is the inverse of the horizontal sync flag, and `vsync_n` is the inverse of the vertical sync flag (`VSYNC_START`..`VSYNC_STOP` on `vcount`). Both hold in every mode.
- R9: `pix_out` is all zeros while `pix_blank` is 1, and equals `pix_in` otherwise.
- R10: When the position equals both start and stop, stop wins. The flag is cleared, so equal start and stop values give an empty window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hcount | input | HCNT_W | Horizontal beam position |
| vcount | input | VCNT_W | Vertical beam position |
| hblank_start | input | HCNT_W | Programmed blank start position |
| hblank_stop | input | HCNT_W | Programmed blank stop position |
| hsync_start | input | HCNT_W | Programmed horizontal sync start position |
| hsync_stop | input | HCNT_W | Programmed horizontal sync stop position |
| blank_en | input | 1 | Composite line carries blanking instead of sync |
| var_sync_en | input | 1 | Use the sync range as the blanking window |
| sync_pol_true | input | 1 | Invert the composite line |
| ext_blank_en | input | 1 | Receiver blanks from the composite line |
| pix_in | input | PIX_W | Pixel data into the receiver gate |
| hsync_n | output | 1 | Active-low horizontal sync |
| vsync_n | output | 1 | Active-low vertical sync |
| csync_line | output | 1 | Shared composite line |
| pix_blank | output | 1 | Receiver blanking state |
| pix_out | output | PIX_W | Gated pixel data |

## Verification
The bench builds the block with a 6-bit horizontal counter, a 4-bit vertical counter and 8-bit pixels. The hardwired window is set to 50..4 and the vertical sync range to lines 1..3. With these values, a whole 64-position line runs in 64 cycles. Both the programmed and the hardwired windows can be placed across the wrap point. The vertical sync flag can be driven on and off within a few lines. This makes it possible to cover every mode combination, the wrap case and the equal start/stop case in a short run.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    localparam int NWIN   = 4;
    localparam int WIN_HB = 0;   // programmed horizontal blank
    localparam int WIN_HS = 1;   // programmed horizontal sync
    localparam int WIN_VS = 2;   // fixed vertical sync
    localparam int WIN_HW = 3;   // hardwired horizontal blank

    typedef struct packed {
        logic blank_en;
        logic var_sync_en;
        logic pol_true;
        logic ext_blank_en;
    } bsync_mode_t;

    typedef struct packed {
        logic hblank;
        logic hsync;
        logic vsync;
        logic hwblank;
    } bsync_flags_t;

    // stop match has priority over start match
    function automatic logic win_next(logic cur, logic at_start, logic at_stop);
        if (at_stop)       return 1'b0;
        else if (at_start) return 1'b1;
        else               return cur;
    endfunction

    // asserted level first, then polarity; line idles high
    function automatic logic line_level(bsync_flags_t f, bsync_mode_t m);
        logic asrt;
        if (m.blank_en)
            asrt = m.var_sync_en ? f.hsync : f.hblank;
        else
            asrt = f.hsync | f.vsync;
        return m.pol_true ? asrt : ~asrt;
    endfunction

endpackage

// File: rtl/bsync_window.sv
module bsync_window #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pos,
    input  logic [W-1:0] start,
    input  logic [W-1:0] stop,
    output logic         active
);
    import bsync_pkg::*;

    logic at_start;
    logic at_stop;

    assign at_start = (pos == start);
    assign at_stop  = (pos == stop);

    always_ff @(posedge clk) begin
        if (rst) active <= 1'b0;
        else     active <= win_next(active, at_start, at_stop);
    end

    a_r2_start_sets: assert property (@(posedge clk) disable iff (rst)
        (pos == start && pos != stop) |=> active);

    a_r10_stop_wins: assert property (@(posedge clk) disable iff (rst)
        (pos == stop) |=> !active);

    a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
        (pos != start && pos != stop) |=> $stable(active));

endmodule

// File: rtl/bsync_line_mux.sv
module bsync_line_mux (
    input  bsync_pkg::bsync_flags_t flags,
    input  bsync_pkg::bsync_mode_t  mode,
    output logic                    line
);
    import bsync_pkg::*;

    always_comb line = line_level(flags, mode);

endmodule

// File: rtl/bsync_blank_gate.sv
module bsync_blank_gate #(
    parameter int PIX_W = 12
) (
    input  logic             line,
    input  logic             hw_window,
    input  logic             ext_en,
    input  logic [PIX_W-1:0] pix_in,
    output logic             blank,
    output logic [PIX_W-1:0] pix_out
);
    always_comb begin
        blank   = ext_en ? ~line : hw_window;
        pix_out = blank ? '0 : pix_in;
    end
endmodule

// File: rtl/blank_sync_sel.sv
module blank_sync_sel #(
    parameter int HCNT_W         = 9,
    parameter int VCNT_W         = 9,
    parameter int PIX_W          = 12,
    parameter int HW_BLANK_START = 400,
    parameter int HW_BLANK_STOP  = 40,
    parameter int VSYNC_START    = 2,
    parameter int VSYNC_STOP     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HCNT_W-1:0] hcount,
    input  logic [VCNT_W-1:0] vcount,
    input  logic [HCNT_W-1:0] hblank_start,
    input  logic [HCNT_W-1:0] hblank_stop,
    input  logic [HCNT_W-1:0] hsync_start,
    input  logic [HCNT_W-1:0] hsync_stop,
    input  logic              blank_en,
    input  logic              var_sync_en,
    input  logic              sync_pol_true,
    input  logic              ext_blank_en,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              csync_line,
    output logic              pix_blank,
    output logic [PIX_W-1:0]  pix_out
);
    import bsync_pkg::*;

    localparam int CW = (HCNT_W > VCNT_W) ? HCNT_W : VCNT_W;

    logic [CW-1:0]   w_pos   [NWIN];
    logic [CW-1:0]   w_start [NWIN];
    logic [CW-1:0]   w_stop  [NWIN];
    logic [NWIN-1:0] w_act;

    always_comb begin
        w_pos[WIN_HB]   = CW'(hcount);
        w_start[WIN_HB] = CW'(hblank_start);
        w_stop[WIN_HB]  = CW'(hblank_stop);
        w_pos[WIN_HS]   = CW'(hcount);
        w_start[WIN_HS] = CW'(hsync_start);
        w_stop[WIN_HS]  = CW'(hsync_stop);
        w_pos[WIN_VS]   = CW'(vcount);
        w_start[WIN_VS] = CW'(VSYNC_START);
        w_stop[WIN_VS]  = CW'(VSYNC_STOP);
        w_pos[WIN_HW]   = CW'(hcount);
        w_start[WIN_HW] = CW'(HW_BLANK_START);
        w_stop[WIN_HW]  = CW'(HW_BLANK_STOP);
    end

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        bsync_window #(.W(CW)) u_win (
            .clk    (clk),
            .rst    (rst),
            .pos    (w_pos[i]),
            .start  (w_start[i]),
            .stop   (w_stop[i]),
            .active (w_act[i])
        );
    end

    bsync_flags_t flags;
    bsync_mode_t  mode;

    always_comb begin
        flags.hblank  = w_act[WIN_HB];
        flags.hsync   = w_act[WIN_HS];
        flags.vsync   = w_act[WIN_VS];
        flags.hwblank = w_act[WIN_HW];
        mode.blank_en     = blank_en;
        mode.var_sync_en  = var_sync_en;
        mode.pol_true     = sync_pol_true;
        mode.ext_blank_en = ext_blank_en;
    end

    bsync_line_mux u_mux (
        .flags (flags),
        .mode  (mode),
        .line  (csync_line)
    );

    bsync_blank_gate #(.PIX_W(PIX_W)) u_gate (
        .line      (csync_line),
        .hw_window (flags.hwblank),
        .ext_en    (mode.ext_blank_en),
        .pix_in    (pix_in),
        .blank     (pix_blank),
        .pix_out   (pix_out)
    );

    assign hsync_n = ~flags.hsync;
    assign vsync_n = ~flags.vsync;

    a_r2_normal_blank: assert property (@(posedge clk) disable iff (rst)
        (ext_blank_en && blank_en && !var_sync_en && !sync_pol_true)
            |-> (pix_blank == w_act[WIN_HB]));

    a_r6_sync_on_line: assert property (@(posedge clk) disable iff (rst)
        (!blank_en && !sync_pol_true && (!hsync_n || !vsync_n)) |-> !csync_line);

    a_r7_hardwired: assert property (@(posedge clk) disable iff (rst)
        !ext_blank_en |-> (pix_blank == w_act[WIN_HW]));

    a_r9_gate_zero: assert property (@(posedge clk) disable iff (rst)
        pix_blank |-> (pix_out == '0));

endmodule

// File: tb/blank_sync_sel_test.sv
module blank_sync_sel_test;
    localparam int HW  = 6;
    localparam int VW  = 4;
    localparam int PW  = 8;
    localparam int HB0 = 50;
    localparam int HB1 = 4;
    localparam int VS0 = 1;
    localparam int VS1 = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic [HW-1:0] hcount;
    logic [VW-1:0] vcount;
    logic [HW-1:0] hbs, hbe, hss, hse;
    logic          blank_en, var_en, pol, ext_en;
    logic [PW-1:0] pix_in;
    logic          hsync_n, vsync_n, csync_line, pix_blank;
    logic [PW-1:0] pix_out;

    blank_sync_sel #(
        .HCNT_W(HW), .VCNT_W(VW), .PIX_W(PW),
        .HW_BLANK_START(HB0), .HW_BLANK_STOP(HB1),
        .VSYNC_START(VS0), .VSYNC_STOP(VS1)
    ) uut (
        .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
        .hblank_start(hbs), .hblank_stop(hbe),
        .hsync_start(hss), .hsync_stop(hse),
        .blank_en(blank_en), .var_sync_en(var_en),
        .sync_pol_true(pol), .ext_blank_en(ext_en),
        .pix_in(pix_in), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .csync_line(csync_line), .pix_blank(pix_blank), .pix_out(pix_out)
    );

    typedef struct {
        string         tag;
        logic          line;
        logic          blank;
        logic          hs_n;
        logic          vs_n;
        logic [PW-1:0] pix;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit mhb, mhs, mvs, mhw;

    function automatic bit wnext(bit cur, int p, int s, int e);
        if (p == e) return 1'b0;
        if (p == s) return 1'b1;
        return cur;
    endfunction

    task automatic chk(string tag, string what, logic act, logic expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
        end
    endtask

    // driver: called at a negedge, returns at the next negedge
    task automatic step(string tag, int h, logic [PW-1:0] px);
        exp_t e;
        bit asrt;
        hcount = HW'(h);
        pix_in = px;
        @(posedge clk);
        mhb = wnext(mhb, h, int'(hbs), int'(hbe));
        mhs = wnext(mhs, h, int'(hss), int'(hse));
        mvs = wnext(mvs, int'(vcount), VS0, VS1);
        mhw = wnext(mhw, h, HB0, HB1);
        if (blank_en) asrt = var_en ? mhs : mhb;
        else          asrt = mhs | mvs;
        e.tag   = tag;
        e.line  = pol ? asrt : !asrt;
        e.blank = ext_en ? !e.line : mhw;
        e.pix   = e.blank ? '0 : px;
        e.hs_n  = !mhs;
        e.vs_n  = !mvs;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: pops one item per edge and compares
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.tag, "csync_line", csync_line, e.line);
            chk(e.tag, "pix_blank", pix_blank, e.blank);
            chk("R8", "hsync_n", hsync_n, e.hs_n);
            chk("R8", "vsync_n", vsync_n, e.vs_n);
            total++;
            if (pix_out !== e.pix) begin
                bad++;
                $display("FAIL R9 pix_out actual=%h expected=%h", pix_out, e.pix);
            end
        end
    end

    task automatic run_line(string tag, int v);
        vcount = VW'(v);
        for (int h = 0; h < (1 << HW); h++)
            step(tag, h, PW'(h * 7 + v * 3 + 1));
    endtask

    task automatic set_mode(logic b, logic vr, logic p, logic x);
        blank_en = b; var_en = vr; pol = p; ext_en = x;
    endtask

    bit finished = 0;

    initial begin
        rst = 1'b1; hcount = '0; vcount = '0; pix_in = '0;
        hbs = 6'd10; hbe = 6'd20; hss = 6'd30; hse = 6'd34;
        set_mode(1, 0, 0, 1);
        mhb = 0; mhs = 0; mvs = 0; mhw = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "hsync_n", hsync_n, 1'b1);
        chk("R1", "vsync_n", vsync_n, 1'b1);
        chk("R1", "csync_line", csync_line, 1'b1);
        chk("R1", "pix_blank", pix_blank, 1'b0);

        run_line("R2", 0);                 // normal programmed blanking
        hbs = 6'd60; hbe = 6'd5;           // wrap across line end
        run_line("R3", 0);
        run_line("R3", 0);
        hbs = 6'd10; hbe = 6'd20;
        set_mode(1, 1, 0, 1);              // sync range as blank window
        run_line("R4", 0);
        set_mode(1, 0, 1, 1);              // inverted line
        run_line("R5", 0);
        set_mode(1, 1, 1, 1);
        run_line("R5", 0);
        set_mode(0, 0, 0, 1);              // composite sync on line
        for (int v = 0; v < 6; v++) run_line("R6", v);
        set_mode(0, 0, 1, 1);
        run_line("R6", 2);
        set_mode(1, 0, 1, 0);              // hardwired window only
        run_line("R7", 0);
        set_mode(0, 0, 0, 0);
        run_line("R7", 2);
        set_mode(1, 0, 0, 1);
        hbs = 6'd15; hbe = 6'd15;          // empty window
        run_line("R10", 0);
        hss = 6'd40; hse = 6'd40;
        run_line("R10", 0);
        @(posedge clk); #2;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule